// File: doc/BRIEF.md
# Banked GPIO Controller with Edge and Level Interrupts

The block is a memory-mapped general-purpose I/O controller for a parameterised number of pins, grouped in 32-pin banks. Software reaches it through a simple 32-bit register port. A write is a single-cycle strobe. Read data comes back combinationally from the address. Through this port, software samples pin levels, chooses each pin's direction, and drives output values. Output values change only through two write-only strobe registers: one sets bits and the other clears them.

Every input passes through a two-flop synchroniser. It then goes either through a two-sample agreement filter or around it, as chosen per pin. After that it reaches an event detector. Each pin can use edge detection, with rising and falling enabled independently, or level detection with its own polarity. Detected events collect in a sticky source register that software clears by writing 1s. A mask reduces the sources to one interrupt line. A separate wake mask feeds a sticky wake status that drives a wake line.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset every register reads zero. All pins are inputs (`pin_oe` = 0), `pin_out` is 0, and `irq_out` and `wake_out` are low.
- R2: Pin n sits in bit (n mod 32) of the word at family base + 4·(n div 32). The byte offsets of the family bases are: config 0x000 (a single word), level 0x004, direction 0x01C, set 0x034, clear 0x04C, rise-enable 0x064, fall-enable 0x07C, filter-bypass 0x094, mask 0x0AC, source 0x0C4, type 0x300, polarity 0x318, wake-mask 0x330, wake-status 0x348.
- R3: The level family is read-only. It returns each pin's synchronised input two clocks after the pin changes, and writes to it have no effect.
- R4: A 1 written to a set (clear) bit drives that pin's `pin_out` high (low) on the next clock. A 0 bit leaves the pin unchanged. No other write changes `pin_out`.
- R5: A direction bit of 1 makes the pin an output (`pin_oe` high), and a 0 makes it an input. Only direction writes change `pin_oe`.
- R6: With type bit 0 (edge mode), a pin records an event on a 0→1 change when its rise-enable bit is set and on a 1→0 change when its fall-enable bit is set. Both may be set at once.
- R7: With type bit 1 (level mode), a pin records an event on every cycle its input is active. Polarity bit 1 means active-low and 0 means active-high. Clearing the source bit while the level persists has no lasting effect.
- R8: With filter-bypass bit 1, the synchronised input goes straight to detection, so a one-cycle pulse is caught. With bit 0, a value must be sampled twice in a row before detection sees it, so a one-cycle pulse is ignored.
- R9: A source bit stays set once an event occurs until software writes 1 to it. Writing 0 leaves it set.
- R10: `irq_out` is high exactly when some source bit is set and its mask bit is 1.
- R11: A wake-status bit is set on an event only when the pin's wake-mask bit is 1. It is cleared by writing 1, and `wake_out` is high while any wake-status bit is set.
- R12: Reads of the set and clear families and of unmapped offsets return 0. The config word reads back what was last written and has no effect on the pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 12 | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | NUM_PINS | Pad input levels, asynchronous |
| pin_out | output | NUM_PINS | Output values |
| pin_oe | output | NUM_PINS | Output enables (1 = output) |
| irq_out | output | 1 | Combined masked interrupt |
| wake_out | output | 1 | Any wake-status bit set |

## Verification
The bound checker watches on every cycle that `pin_out` and `pin_oe` move only after a strobe or direction write, that set and clear take effect one clock later, that source bits stay set until a matching write-1 clears them, and that the interrupt and wake lines rise only when a mask permits them. The detection behaviour needs the bench's scenarios to show it. Those scenarios cover rising, falling and both-edge capture, level capture in each polarity that survives clearing, a one-cycle pulse that the filter rejects but bypass catches, and the decoding of the banked address families. A behavioural reference model in the bench follows every clock and compares the outputs and every read.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
   localparam int ADDR_W    = 12;
   localparam int WORD_W    = 32;
   localparam int MAX_BANKS = 6;

   typedef logic [ADDR_W-1:0] addr_t;
   typedef logic [WORD_W-1:0] word_t;

   localparam addr_t OFF_CFG  = 12'h000;
   localparam addr_t OFF_LVL  = 12'h004;
   localparam addr_t OFF_DIR  = 12'h01C;
   localparam addr_t OFF_SET  = 12'h034;
   localparam addr_t OFF_CLR  = 12'h04C;
   localparam addr_t OFF_REN  = 12'h064;
   localparam addr_t OFF_FEN  = 12'h07C;
   localparam addr_t OFF_BYP  = 12'h094;
   localparam addr_t OFF_MSK  = 12'h0AC;
   localparam addr_t OFF_SRC  = 12'h0C4;
   localparam addr_t OFF_TYP  = 12'h300;
   localparam addr_t OFF_POL  = 12'h318;
   localparam addr_t OFF_WMSK = 12'h330;
   localparam addr_t OFF_WSTS = 12'h348;

   // True when address a selects bank 'bank' of the family at 'base'.
   function automatic logic bank_hit(addr_t a, addr_t base, int bank);
      addr_t tgt;
      tgt = base + addr_t'(4 * bank);
      return a[ADDR_W-1:2] == tgt[ADDR_W-1:2];
   endfunction
endpackage

// File: rtl/gpio_in_stage.sv
module gpio_in_stage #(
   parameter int NUM_PINS   = 64,
   parameter bit HAS_FILTER = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] pin_in,
   input  logic [NUM_PINS-1:0] bypass,
   output logic [NUM_PINS-1:0] level_o,
   output logic [NUM_PINS-1:0] det_o
);
   logic [NUM_PINS-1:0] s1_q, s2_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_q <= '0;
         s2_q <= '0;
      end else begin
         s1_q <= pin_in;
         s2_q <= s1_q;
      end
   end

   assign level_o = s2_q;

   generate
      if (HAS_FILTER) begin : g_filt
         logic [NUM_PINS-1:0] s2_d_q, filt_q, agree;
         assign agree = ~(s2_q ^ s2_d_q);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               s2_d_q <= '0;
               filt_q <= '0;
            end else begin
               s2_d_q <= s2_q;
               filt_q <= (s2_q & agree) | (filt_q & ~agree);
            end
         end
         assign det_o = (bypass & s2_q) | (~bypass & filt_q);
      end else begin : g_raw
         logic unused_bypass;
         assign unused_bypass = ^bypass;
         assign det_o = s2_q;
      end
   endgenerate
endmodule

// File: rtl/gpio_event_det.sv
module gpio_event_det #(
   parameter int NUM_PINS = 64
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] det_i,
   input  logic [NUM_PINS-1:0] ren,
   input  logic [NUM_PINS-1:0] fen,
   input  logic [NUM_PINS-1:0] typ,
   input  logic [NUM_PINS-1:0] pol,
   output logic [NUM_PINS-1:0] evt_o
);
   logic [NUM_PINS-1:0] prev_q, rise, fall, active;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= det_i;
   end

   assign rise   = det_i & ~prev_q;
   assign fall   = ~det_i & prev_q;
   assign active = det_i ^ pol;
   assign evt_o  = (typ & active) | (~typ & ((rise & ren) | (fall & fen)));
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
   import gpio_bank_pkg::*;
#(
   parameter int NUM_PINS = 64
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_wr,
   input  addr_t               bus_addr,
   input  word_t               bus_wdata,
   output word_t               bus_rdata,
   input  logic [NUM_PINS-1:0] level_i,
   input  logic [NUM_PINS-1:0] evt_i,
   output logic [NUM_PINS-1:0] dir_o,
   output logic [NUM_PINS-1:0] out_o,
   output logic [NUM_PINS-1:0] ren_o,
   output logic [NUM_PINS-1:0] fen_o,
   output logic [NUM_PINS-1:0] byp_o,
   output logic [NUM_PINS-1:0] msk_o,
   output logic [NUM_PINS-1:0] typ_o,
   output logic [NUM_PINS-1:0] pol_o,
   output logic [NUM_PINS-1:0] wmsk_o,
   output logic [NUM_PINS-1:0] src_o,
   output logic [NUM_PINS-1:0] wsts_o
);
   localparam int BANKS = NUM_PINS / WORD_W;

   word_t               cfg_q;
   logic [NUM_PINS-1:0] dir_q, out_q, ren_q, fen_q, byp_q, msk_q;
   logic [NUM_PINS-1:0] typ_q, pol_q, wmsk_q, src_q, wsts_q;
   logic [NUM_PINS-1:0] set_m, clr_m, src_clr, wsts_clr;

   // Write-one strobes decoded per bank.
   always_comb begin
      set_m    = '0;
      clr_m    = '0;
      src_clr  = '0;
      wsts_clr = '0;
      for (int b = 0; b < BANKS; b++) begin
         if (bus_wr && bank_hit(bus_addr, OFF_SET, b))  set_m[b*WORD_W +: WORD_W]    = bus_wdata;
         if (bus_wr && bank_hit(bus_addr, OFF_CLR, b))  clr_m[b*WORD_W +: WORD_W]    = bus_wdata;
         if (bus_wr && bank_hit(bus_addr, OFF_SRC, b))  src_clr[b*WORD_W +: WORD_W]  = bus_wdata;
         if (bus_wr && bank_hit(bus_addr, OFF_WSTS, b)) wsts_clr[b*WORD_W +: WORD_W] = bus_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q  <= '0;
         dir_q  <= '0;
         out_q  <= '0;
         ren_q  <= '0;
         fen_q  <= '0;
         byp_q  <= '0;
         msk_q  <= '0;
         typ_q  <= '0;
         pol_q  <= '0;
         wmsk_q <= '0;
         src_q  <= '0;
         wsts_q <= '0;
      end else begin
         out_q  <= (out_q | set_m) & ~clr_m;
         // Events win over a same-cycle clear so a held level re-asserts.
         src_q  <= (src_q & ~src_clr) | evt_i;
         wsts_q <= (wsts_q & ~wsts_clr) | (evt_i & wmsk_q);
         if (bus_wr) begin
            if (bank_hit(bus_addr, OFF_CFG, 0)) cfg_q <= bus_wdata;
            for (int b = 0; b < BANKS; b++) begin
               if (bank_hit(bus_addr, OFF_DIR, b))  dir_q[b*WORD_W +: WORD_W]  <= bus_wdata;
               if (bank_hit(bus_addr, OFF_REN, b))  ren_q[b*WORD_W +: WORD_W]  <= bus_wdata;
               if (bank_hit(bus_addr, OFF_FEN, b))  fen_q[b*WORD_W +: WORD_W]  <= bus_wdata;
               if (bank_hit(bus_addr, OFF_BYP, b))  byp_q[b*WORD_W +: WORD_W]  <= bus_wdata;
               if (bank_hit(bus_addr, OFF_MSK, b))  msk_q[b*WORD_W +: WORD_W]  <= bus_wdata;
               if (bank_hit(bus_addr, OFF_TYP, b))  typ_q[b*WORD_W +: WORD_W]  <= bus_wdata;
               if (bank_hit(bus_addr, OFF_POL, b))  pol_q[b*WORD_W +: WORD_W]  <= bus_wdata;
               if (bank_hit(bus_addr, OFF_WMSK, b)) wmsk_q[b*WORD_W +: WORD_W] <= bus_wdata;
            end
         end
      end
   end

   // Read mux; write-only and unmapped offsets fall through to zero.
   always_comb begin
      bus_rdata = '0;
      if (bank_hit(bus_addr, OFF_CFG, 0)) bus_rdata = cfg_q;
      for (int b = 0; b < BANKS; b++) begin
         if (bank_hit(bus_addr, OFF_LVL, b))  bus_rdata = level_i[b*WORD_W +: WORD_W];
         if (bank_hit(bus_addr, OFF_DIR, b))  bus_rdata = dir_q[b*WORD_W +: WORD_W];
         if (bank_hit(bus_addr, OFF_REN, b))  bus_rdata = ren_q[b*WORD_W +: WORD_W];
         if (bank_hit(bus_addr, OFF_FEN, b))  bus_rdata = fen_q[b*WORD_W +: WORD_W];
         if (bank_hit(bus_addr, OFF_BYP, b))  bus_rdata = byp_q[b*WORD_W +: WORD_W];
         if (bank_hit(bus_addr, OFF_MSK, b))  bus_rdata = msk_q[b*WORD_W +: WORD_W];
         if (bank_hit(bus_addr, OFF_SRC, b))  bus_rdata = src_q[b*WORD_W +: WORD_W];
         if (bank_hit(bus_addr, OFF_TYP, b))  bus_rdata = typ_q[b*WORD_W +: WORD_W];
         if (bank_hit(bus_addr, OFF_POL, b))  bus_rdata = pol_q[b*WORD_W +: WORD_W];
         if (bank_hit(bus_addr, OFF_WMSK, b)) bus_rdata = wmsk_q[b*WORD_W +: WORD_W];
         if (bank_hit(bus_addr, OFF_WSTS, b)) bus_rdata = wsts_q[b*WORD_W +: WORD_W];
      end
   end

   assign dir_o  = dir_q;
   assign out_o  = out_q;
   assign ren_o  = ren_q;
   assign fen_o  = fen_q;
   assign byp_o  = byp_q;
   assign msk_o  = msk_q;
   assign typ_o  = typ_q;
   assign pol_o  = pol_q;
   assign wmsk_o = wmsk_q;
   assign src_o  = src_q;
   assign wsts_o = wsts_q;
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
   import gpio_bank_pkg::*;
#(
   parameter int NUM_PINS   = 64,
   parameter bit HAS_FILTER = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_wr,
   input  logic [11:0]         bus_addr,
   input  logic [31:0]         bus_wdata,
   output logic [31:0]         bus_rdata,
   input  logic [NUM_PINS-1:0] pin_in,
   output logic [NUM_PINS-1:0] pin_out,
   output logic [NUM_PINS-1:0] pin_oe,
   output logic                irq_out,
   output logic                wake_out
);
   localparam int BANKS = NUM_PINS / WORD_W;

   generate
      if (NUM_PINS % WORD_W != 0 || BANKS < 1 || BANKS > MAX_BANKS) begin : g_bad_pins
         $error("gpio_bank_ctrl: NUM_PINS must be a multiple of 32, 32 to 192");
      end
   endgenerate

   logic [NUM_PINS-1:0] level_w, det_w, evt_w;
   logic [NUM_PINS-1:0] ren_w, fen_w, byp_w, msk_w, typ_w, pol_w, wmsk_w, src_w, wsts_w;

   gpio_in_stage #(.NUM_PINS(NUM_PINS), .HAS_FILTER(HAS_FILTER)) u_in (
      .clk     (clk),
      .rst_n   (rst_n),
      .pin_in  (pin_in),
      .bypass  (byp_w),
      .level_o (level_w),
      .det_o   (det_w)
   );

   gpio_event_det #(.NUM_PINS(NUM_PINS)) u_det (
      .clk   (clk),
      .rst_n (rst_n),
      .det_i (det_w),
      .ren   (ren_w),
      .fen   (fen_w),
      .typ   (typ_w),
      .pol   (pol_w),
      .evt_o (evt_w)
   );

   gpio_bank_regs #(.NUM_PINS(NUM_PINS)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .level_i   (level_w),
      .evt_i     (evt_w),
      .dir_o     (pin_oe),
      .out_o     (pin_out),
      .ren_o     (ren_w),
      .fen_o     (fen_w),
      .byp_o     (byp_w),
      .msk_o     (msk_w),
      .typ_o     (typ_w),
      .pol_o     (pol_w),
      .wmsk_o    (wmsk_w),
      .src_o     (src_w),
      .wsts_o    (wsts_w)
   );

   assign irq_out  = |(src_w & msk_w);
   assign wake_out = |wsts_w;
endmodule

// File: rtl/gpio_bank_ctrl_chk.sv
module gpio_bank_ctrl_chk
   import gpio_bank_pkg::*;
#(
   parameter int NUM_PINS = 64
) (
   input logic                clk,
   input logic                rst_n,
   input logic                bus_wr,
   input logic [11:0]         bus_addr,
   input logic [31:0]         bus_wdata,
   input logic [NUM_PINS-1:0] pin_out,
   input logic [NUM_PINS-1:0] pin_oe,
   input logic                irq_out,
   input logic                wake_out,
   input logic [NUM_PINS-1:0] src_w,
   input logic [NUM_PINS-1:0] msk_w,
   input logic [NUM_PINS-1:0] wmsk_w,
   input logic [NUM_PINS-1:0] evt_w
);
   localparam int BANKS = NUM_PINS / WORD_W;

   logic dir_wr, strobe_wr, src0_clr;
   always_comb begin
      dir_wr    = 1'b0;
      strobe_wr = 1'b0;
      for (int b = 0; b < BANKS; b++) begin
         if (bus_wr && bank_hit(bus_addr, OFF_DIR, b)) dir_wr = 1'b1;
         if (bus_wr && (bank_hit(bus_addr, OFF_SET, b) || bank_hit(bus_addr, OFF_CLR, b))) strobe_wr = 1'b1;
      end
   end
   assign src0_clr = bus_wr && bank_hit(bus_addr, OFF_SRC, 0) && bus_wdata[0];

   AST_OE_ONLY_BY_DIR: assert property (@(posedge clk) disable iff (!rst_n)
      !dir_wr |=> $stable(pin_oe)); // R5
   AST_OUT_ONLY_BY_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      !strobe_wr |=> $stable(pin_out)); // R4
   AST_SET_TAKES_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bank_hit(bus_addr, OFF_SET, 0) && bus_wdata[0]) |=> pin_out[0]); // R4
   AST_CLR_TAKES_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bank_hit(bus_addr, OFF_CLR, 0) && bus_wdata[0]) |=> !pin_out[0]); // R4
   AST_SRC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (src_w[0] && !src0_clr) |=> src_w[0]); // R9
   AST_SRC_W1C: assert property (@(posedge clk) disable iff (!rst_n)
      (src0_clr && !evt_w[0]) |=> !src_w[0]); // R9
   AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out |-> (msk_w != '0) && (src_w != '0)); // R10
   AST_WAKE_NEEDS_WMASK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wake_out) |-> $past(wmsk_w != '0)); // R11
endmodule

bind gpio_bank_ctrl gpio_bank_ctrl_chk #(.NUM_PINS(NUM_PINS)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .pin_out   (pin_out),
   .pin_oe    (pin_oe),
   .irq_out   (irq_out),
   .wake_out  (wake_out),
   .src_w     (src_w),
   .msk_w     (msk_w),
   .wmsk_w    (wmsk_w),
   .evt_w     (evt_w)
);

// File: tb/gpio_bank_ctrl_bench.sv
module gpio_bank_ctrl_bench;
   localparam int NP = 64;
   localparam int NB = NP / 32;
   localparam int A_CFG = 'h000, A_LVL = 'h004, A_DIR = 'h01C, A_SET = 'h034, A_CLR = 'h04C;
   localparam int A_REN = 'h064, A_FEN = 'h07C, A_BYP = 'h094, A_MSK = 'h0AC, A_SRC = 'h0C4;
   localparam int A_TYP = 'h300, A_POL = 'h318, A_WMSK = 'h330, A_WSTS = 'h348;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_wr = 1'b0;
   logic [11:0]   bus_addr = 12'hFFC;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic [NP-1:0] pin_in = '0;
   logic [NP-1:0] pin_out, pin_oe;
   logic          irq_out, wake_out;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   gpio_bank_ctrl #(.NUM_PINS(NP)) u_gpio_bank_ctrl (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
      .pin_out(pin_out), .pin_oe(pin_oe), .irq_out(irq_out), .wake_out(wake_out)
   );

   // ---------------- behavioural reference model ----------------
   logic [NP-1:0] m_s1, m_s2, m_s2d, m_filt, m_prev;
   logic [NP-1:0] m_dir, m_out, m_ren, m_fen, m_byp, m_msk, m_typ, m_pol, m_wmsk, m_src, m_wsts;
   logic [31:0]   m_cfg;

   function automatic int fam(input logic [11:0] a, input int base);
      int ai = int'(a) & ~3;
      if (ai >= base && ai < base + 4 * NB) return (ai - base) / 4;
      return -1;
   endfunction

   function automatic logic [31:0] m_read(input logic [11:0] a);
      int b;
      if ((int'(a) & ~3) == A_CFG) return m_cfg;
      b = fam(a, A_LVL);  if (b >= 0) return m_s2[b*32 +: 32];
      b = fam(a, A_DIR);  if (b >= 0) return m_dir[b*32 +: 32];
      b = fam(a, A_REN);  if (b >= 0) return m_ren[b*32 +: 32];
      b = fam(a, A_FEN);  if (b >= 0) return m_fen[b*32 +: 32];
      b = fam(a, A_BYP);  if (b >= 0) return m_byp[b*32 +: 32];
      b = fam(a, A_MSK);  if (b >= 0) return m_msk[b*32 +: 32];
      b = fam(a, A_SRC);  if (b >= 0) return m_src[b*32 +: 32];
      b = fam(a, A_TYP);  if (b >= 0) return m_typ[b*32 +: 32];
      b = fam(a, A_POL);  if (b >= 0) return m_pol[b*32 +: 32];
      b = fam(a, A_WMSK); if (b >= 0) return m_wmsk[b*32 +: 32];
      b = fam(a, A_WSTS); if (b >= 0) return m_wsts[b*32 +: 32];
      return 32'h0;
   endfunction

   always @(posedge clk or negedge rst_n) begin : model
      logic [NP-1:0] det, ev, wset, setm, clrm, sclr, wclr;
      int b;
      if (!rst_n) begin
         m_s1 = '0; m_s2 = '0; m_s2d = '0; m_filt = '0; m_prev = '0;
         m_dir = '0; m_out = '0; m_ren = '0; m_fen = '0; m_byp = '0; m_msk = '0;
         m_typ = '0; m_pol = '0; m_wmsk = '0; m_src = '0; m_wsts = '0; m_cfg = '0;
      end else begin
         for (int i = 0; i < NP; i++) begin
            det[i] = m_byp[i] ? m_s2[i] : m_filt[i];
            if (m_typ[i]) ev[i] = det[i] ^ m_pol[i];
            else ev[i] = (m_ren[i] & det[i] & ~m_prev[i]) | (m_fen[i] & ~det[i] & m_prev[i]);
         end
         wset = ev & m_wmsk;
         setm = '0; clrm = '0; sclr = '0; wclr = '0;
         if (bus_wr) begin
            if ((int'(bus_addr) & ~3) == A_CFG) m_cfg = bus_wdata;
            b = fam(bus_addr, A_DIR);  if (b >= 0) m_dir[b*32 +: 32] = bus_wdata;
            b = fam(bus_addr, A_SET);  if (b >= 0) setm[b*32 +: 32] = bus_wdata;
            b = fam(bus_addr, A_CLR);  if (b >= 0) clrm[b*32 +: 32] = bus_wdata;
            b = fam(bus_addr, A_REN);  if (b >= 0) m_ren[b*32 +: 32] = bus_wdata;
            b = fam(bus_addr, A_FEN);  if (b >= 0) m_fen[b*32 +: 32] = bus_wdata;
            b = fam(bus_addr, A_BYP);  if (b >= 0) m_byp[b*32 +: 32] = bus_wdata;
            b = fam(bus_addr, A_MSK);  if (b >= 0) m_msk[b*32 +: 32] = bus_wdata;
            b = fam(bus_addr, A_SRC);  if (b >= 0) sclr[b*32 +: 32] = bus_wdata;
            b = fam(bus_addr, A_TYP);  if (b >= 0) m_typ[b*32 +: 32] = bus_wdata;
            b = fam(bus_addr, A_POL);  if (b >= 0) m_pol[b*32 +: 32] = bus_wdata;
            b = fam(bus_addr, A_WMSK); if (b >= 0) m_wmsk[b*32 +: 32] = bus_wdata;
            b = fam(bus_addr, A_WSTS); if (b >= 0) wclr[b*32 +: 32] = bus_wdata;
         end
         for (int i = 0; i < NP; i++)
            if (m_s2[i] == m_s2d[i]) m_filt[i] = m_s2[i];
         m_prev = det;
         m_s2d  = m_s2;
         m_s2   = m_s1;
         m_s1   = pin_in;
         m_out  = (m_out | setm) & ~clrm;
         m_src  = (m_src & ~sclr) | ev;
         m_wsts = (m_wsts & ~wclr) | wset;
      end
   end

   // ---------------- checking ----------------
   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk(pin_out === m_out, "R4 pin_out vs model", pin_out, m_out);
         chk(pin_oe === m_dir, "R5 pin_oe vs model", pin_oe, m_dir);
         chk(irq_out === |(m_src & m_msk), "R10 irq_out vs model", 64'(irq_out), 64'(|(m_src & m_msk)));
         chk(wake_out === |m_wsts, "R11 wake_out vs model", 64'(wake_out), 64'(|m_wsts));
      end
   end

   task automatic wr(input int a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = 12'(a); bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0; bus_addr = 12'hFFC; bus_wdata = '0;
   endtask

   task automatic rd(input int a, input string tag, output logic [31:0] d);
      @(negedge clk);
      bus_addr = 12'(a);
      #1;
      d = bus_rdata;
      chk(d === m_read(12'(a)), tag, 64'(d), 64'(m_read(12'(a))));
      bus_addr = 12'hFFC;
   endtask

   task automatic pin(input int idx, input logic v);
      @(negedge clk);
      pin_in[idx] = v;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++; errors++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      chk(pin_oe === '0 && pin_out === '0, "R1 pins after reset", {pin_oe[31:0], pin_out[31:0]}, 64'h0);
      chk(!irq_out && !wake_out, "R1 irq/wake after reset", {irq_out, wake_out}, 64'h0);
      rd(A_DIR, "R1 dir reads 0", d); chk(d == 0, "R1 dir zero", d, 0);
      rd(A_SRC, "R1 src reads 0", d); chk(d == 0, "R1 src zero", d, 0);

      // R5: direction
      wr(A_DIR, 32'hF0);
      chk(pin_oe[7:0] == 8'hF0, "R5 dir bits to pin_oe", pin_oe[7:0], 8'hF0);

      // R4 / R12: set and clear strobes
      wr(A_SET, 32'h30);
      chk(pin_out[7:0] == 8'h30, "R4 set drives high", pin_out[7:0], 8'h30);
      wr(A_SET, 32'h0);
      chk(pin_out[7:0] == 8'h30, "R4 zero set no change", pin_out[7:0], 8'h30);
      wr(A_CLR, 32'h10);
      chk(pin_out[7:0] == 8'h20, "R4 clear drives low", pin_out[7:0], 8'h20);
      rd(A_SET, "R12 set reads", d); chk(d == 0, "R12 set reads zero", d, 0);
      rd(A_CLR, "R12 clr reads", d); chk(d == 0, "R12 clr reads zero", d, 0);
      rd('h3F0, "R12 unmapped read", d); chk(d == 0, "R12 unmapped zero", d, 0);
      wr(A_CFG, 32'hA5);
      rd(A_CFG, "R12 cfg readback", d); chk(d == 32'hA5, "R12 cfg holds", d, 32'hA5);

      // R2: second bank addressing
      wr(A_SET + 4, 32'h8);
      chk(pin_out[35] == 1'b1, "R2 bank1 bit3 is pin35", pin_out[35], 1);
      wr(A_DIR + 4, 32'h1);
      chk(pin_oe[32] == 1'b1, "R2 bank1 dir bit0 is pin32", pin_oe[32], 1);

      // R3: level register, read-only
      pin(2, 1'b1); idle(4);
      rd(A_LVL, "R3 level read", d); chk(d[2] == 1'b1, "R3 level bit2", d[2], 1);
      wr(A_LVL, 32'h0);
      rd(A_LVL, "R3 level after write", d); chk(d[2] == 1'b1, "R3 write ignored", d[2], 1);

      // R6: edge detection with bypass
      wr(A_BYP, 32'hFFFF_FFFF);
      wr(A_REN, 32'h5);
      wr(A_FEN, 32'h6);
      wr(A_MSK, 32'h7);
      idle(3);
      pin(0, 1'b1); idle(5);
      rd(A_SRC, "R6 rise pin0", d); chk(d[2:0] == 3'b001, "R6 rising edge", d[2:0], 3'b001);
      pin(1, 1'b1); idle(5);
      rd(A_SRC, "R6 rise pin1", d); chk(d[2:0] == 3'b001, "R6 rise ignored on fall-only pin", d[2:0], 3'b001);
      pin(1, 1'b0); idle(5);
      rd(A_SRC, "R6 fall pin1", d); chk(d[2:0] == 3'b011, "R6 falling edge", d[2:0], 3'b011);
      pin(2, 1'b0); idle(5);
      rd(A_SRC, "R6 both pin2", d); chk(d[2:0] == 3'b111, "R6 both-edge fall", d[2:0], 3'b111);
      chk(irq_out == 1'b1, "R10 irq with mask", irq_out, 1);

      // R9: write-1-to-clear
      wr(A_SRC, 32'h0);
      rd(A_SRC, "R9 w0", d); chk(d[2:0] == 3'b111, "R9 zero write keeps", d[2:0], 3'b111);
      wr(A_SRC, 32'h7);
      rd(A_SRC, "R9 w1", d); chk(d[2:0] == 3'b000, "R9 one write clears", d[2:0], 3'b000);
      chk(irq_out == 1'b0, "R10 irq drops", irq_out, 0);
      pin(0, 1'b0); idle(5); pin(0, 1'b1); idle(5);
      wr(A_MSK, 32'h0);
      chk(irq_out == 1'b0, "R10 masked source", irq_out, 0);
      wr(A_SRC, 32'h7);

      // R7: level mode, polarity first then type
      wr(A_POL, 32'h100);
      wr(A_TYP, 32'h300);
      idle(4);
      rd(A_SRC, "R7 level", d); chk(d[9:8] == 2'b01, "R7 active-low captured", d[9:8], 2'b01);
      wr(A_SRC, 32'h100);
      rd(A_SRC, "R7 persist", d); chk(d[8] == 1'b1, "R7 clear ineffective while active", d[8], 1);
      pin(8, 1'b1); idle(5);
      wr(A_SRC, 32'h100);
      rd(A_SRC, "R7 inactive clear", d); chk(d[8] == 1'b0, "R7 clear after inactive", d[8], 0);
      pin(9, 1'b1); idle(5);
      rd(A_SRC, "R7 high", d); chk(d[9] == 1'b1, "R7 active-high captured", d[9], 1);
      wr(A_TYP, 32'h0);
      wr(A_SRC, 32'hFFFF_FFFF);

      // R8: glitch filter versus bypass
      wr(A_BYP, 32'hFFFE_FFFF);
      wr(A_REN, 32'h0001_0005);
      idle(4);
      pin(16, 1'b1); pin(16, 1'b0); idle(8);
      rd(A_SRC, "R8 filtered pulse", d); chk(d[16] == 1'b0, "R8 pulse rejected", d[16], 0);
      pin(16, 1'b1); idle(6);
      rd(A_SRC, "R8 filtered steady", d); chk(d[16] == 1'b1, "R8 steady passes", d[16], 1);
      pin(16, 1'b0); idle(6);
      wr(A_SRC, 32'h0001_0000);
      wr(A_BYP, 32'hFFFF_FFFF);
      idle(2);
      pin(16, 1'b1); pin(16, 1'b0); idle(6);
      rd(A_SRC, "R8 bypass pulse", d); chk(d[16] == 1'b1, "R8 pulse caught bypassed", d[16], 1);

      // R11: wake status
      wr(A_WMSK, 32'h1);
      pin(1, 1'b1); idle(3); pin(1, 1'b0); idle(5);
      chk(wake_out == 1'b0, "R11 unmasked pin no wake", wake_out, 0);
      pin(0, 1'b0); idle(3); pin(0, 1'b1); idle(5);
      chk(wake_out == 1'b1, "R11 wake set", wake_out, 1);
      rd(A_WSTS, "R11 wake read", d); chk(d[1:0] == 2'b01, "R11 wake bit", d[1:0], 2'b01);
      wr(A_WSTS, 32'h1);
      chk(wake_out == 1'b0, "R11 wake cleared", wake_out, 0);

      idle(4);
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule